// File: doc/BRIEF.md
# I2C Master Register and Sequencer

This block is the software-facing half of an I2C master. A processor reaches it through 32-bit register reads and writes on a simple valid/ready bus. Software loads a target address and a byte count, then writes the control word to open a transfer. The block drives an abstract byte-level bus engine over a request/acknowledge link. The engine understands four operations: start with address, send one byte, receive one byte, and stop. Pin timing lives inside that engine and is not part of this block.

There is no FIFO. Each access to the data port moves one byte through the engine and counts the remaining length down by one. When the count reaches zero the block issues a stop on its own. A transfer that opens with a count of zero is finished at once, which gives a quick (address-only) command. Clearing the completion flag reloads the count with the value software last wrote. Three timing values (clock divider, data delay, clock-stretch timeout) are held in registers and driven out to the engine. The block does not interpret them. One interrupt line combines three sources, and each source has its own enable.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset the registers read as follows: control 0; status 0x50, which is tx-room (bit 4) and tx-empty (bit 6); length 0; target address 0; divider 0x5DC; delay 0x00300030; timeout 0x40. The interrupt output is low.
- R2: A write to control (offset 0x00) opens a transfer when either go (bit 4) or enable (bit 15) is set. Opening a transfer issues engine op 0 (start), carrying the stored target address and the direction bit (bit 0, 1 = read). Go always reads back 0. Bits 0, 8, 9, 10 and 15 are stored and read back.
- R3: When the start op is acknowledged, busy (status bit 0) is set. A read also sets rx-ready (bit 3) and rx-data (bit 5). A write also sets tx-wanted (bit 2). If the address was not acknowledged, error (bit 8) is set.
- R4: If the length is zero when a transfer opens, a stop (engine op 3) follows the start directly and the transfer completes.
- R5: Finishing a transfer issues a stop, then sets done (status bit 1) and clears bits 0, 2, 3 and 5.
- R6: A data write (offset 0x10) while busy issues engine op 1 (send) with write-data bits 7:0. On an acknowledged byte the length drops by one. On a refused byte the error bit is set and the length is unchanged. A length of zero afterwards finishes the transfer. A data write while not busy is ignored, and no engine op is issued.
- R7: A data read (offset 0x10) while busy issues engine op 2 (receive) and returns the byte in bits 7:0. The length drops by one and the transfer finishes at zero. A data read while not busy returns 0 and issues no engine op.
- R8: In status (offset 0x04), done (bit 1), error (bit 8) and timeout (bit 9) are write-1-to-clear. Clearing a done that was set restores the length to the value last written at offset 0x08.
- R9: The interrupt is high when any of these pairs is true: control bit 8 with rx-ready, control bit 9 with tx-wanted, or control bit 10 with done.
- R10: While an engine request is outstanding, bus ready stays low and the request fields hold steady until the acknowledge. An access that needs the engine completes only after all of its engine ops.
- R11: The length (0x08), target address (0x0C), divider (0x14), delay (0x18) and timeout (0x1C) registers store what is written. The last three drive the configuration outputs. Offsets at or above 0x20, and offsets that are not a multiple of four, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | 32 | Read data, valid with ready |
| irq | output | 1 | Interrupt request |
| eng_req | output | 1 | Engine operation request |
| eng_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| eng_slave | output | SLV_W | Target address for start |
| eng_rnw | output | 1 | Direction for start, 1 = read |
| eng_wbyte | output | 8 | Byte for send |
| eng_ack | input | 1 | One-cycle completion of the request |
| eng_nack | input | 1 | With ack: address or byte not acknowledged |
| eng_rbyte | input | 8 | With ack: received byte |
| cfg_div | output | 32 | Stored clock divider |
| cfg_delay | output | 32 | Stored data delay |
| cfg_timeout | output | 32 | Stored clock-stretch timeout |

## Verification
The bench builds the block with LEN_W = 4, SLV_W = 7 and ADDR_W = 6. With a 4-bit length, writing zero to the length during an open transfer and then sending a byte wraps the count to 15, so that corner is reached by ordinary random traffic. Short counts also finish transfers often, so stop, done and reload sequences come up many times in one run. A 6-bit offset lets the bench touch the eight mapped words, the unmapped words from 0x20 to 0x3C, and misaligned offsets.

// File: rtl/i2c_host_pkg.sv
// Package: shared encodings for the I2C master register block.
// Assumes: register offsets are byte offsets with 32-bit words.
package i2c_host_pkg;

    // Engine operation codes
    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } eng_op_e;

    // Decoded register selection
    typedef enum logic [3:0] {
        SEL_CTRL, SEL_STAT, SEL_LEN, SEL_SADDR,
        SEL_DATA, SEL_DIV,  SEL_DELAY, SEL_TMO, SEL_NONE
    } reg_sel_e;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE, ST_XFER, ST_STOP, ST_FIN
    } seq_state_e;

    // Control word bit positions
    localparam int CTRL_DIR    = 0;
    localparam int CTRL_GO     = 4;
    localparam int CTRL_RXIE   = 8;
    localparam int CTRL_TXIE   = 9;
    localparam int CTRL_DONEIE = 10;
    localparam int CTRL_EN     = 15;

    // Status word bit positions
    localparam int STB_BUSY = 0;
    localparam int STB_DONE = 1;
    localparam int STB_TXW  = 2;
    localparam int STB_RXR  = 3;
    localparam int STB_TXD  = 4;
    localparam int STB_RXD  = 5;
    localparam int STB_TXE  = 6;
    localparam int STB_ERR  = 8;
    localparam int STB_CLKT = 9;

    // Number of stored configuration words (divider, delay, timeout)
    localparam int N_CFG = 3;

endpackage

// File: rtl/i2c_host_cfg.sv
// Module: configuration storage (target address, divider, delay, timeout).
// Assumes: wr_en is asserted for exactly one cycle per accepted write;
//          values are held and driven out, never interpreted here.
module i2c_host_cfg
    import i2c_host_pkg::*;
#(
    parameter int          SLV_W   = 7,
    parameter logic [31:0] DIV_RST = 32'h0000_05DC,
    parameter logic [31:0] DEL_RST = 32'h0030_0030,
    parameter logic [31:0] TMO_RST = 32'h0000_0040
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  reg_sel_e                    sel,
    input  logic [31:0]                 wdata,
    output logic [SLV_W-1:0]            slave_q,
    output logic [N_CFG-1:0][31:0]      cfg_q
);

    // Reset value of configuration word i
    function automatic logic [31:0] rst_val(input int i);
        case (i)
            0:       return DIV_RST;
            1:       return DEL_RST;
            default: return TMO_RST;
        endcase
    endfunction

    // Register selection that addresses configuration word i
    function automatic reg_sel_e word_sel(input int i);
        case (i)
            0:       return SEL_DIV;
            1:       return SEL_DELAY;
            default: return SEL_TMO;
        endcase
    endfunction

    // Target address register
    always_ff @(posedge clk) begin
        if (!rst_n)                       slave_q <= '0;
        else if (wr_en && sel == SEL_SADDR) slave_q <= wdata[SLV_W-1:0];
    end

    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        // One stored configuration word
        always_ff @(posedge clk) begin
            if (!rst_n)                         cfg_q[g] <= rst_val(g);
            else if (wr_en && sel == word_sel(g)) cfg_q[g] <= wdata;
        end
    end

endmodule

// File: rtl/i2c_host_irq.sv
// Module: interrupt combiner.
// Assumes: inputs come straight from flops, so the output is glitch-limited
//          to register updates.
module i2c_host_irq (
    input  logic rx_ie,
    input  logic tx_ie,
    input  logic done_ie,
    input  logic rx_ready,
    input  logic tx_want,
    input  logic done,
    output logic irq
);

    // Any enabled pending source raises the line
    always_comb irq = (rx_ie & rx_ready) | (tx_ie & tx_want) | (done_ie & done);

endmodule

// File: rtl/i2c_host_seq.sv
// Module: transfer sequencer with control, status and length registers.
// Assumes: the bus master keeps the access stable until acc_ready; the
//          engine answers each request with a single-cycle eng_ack.
module i2c_host_seq
    import i2c_host_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  reg_sel_e          acc_sel,
    input  logic [31:0]       acc_wdata,
    output logic              acc_ready,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       stat_word,
    output logic [31:0]       len_word,
    output logic [31:0]       data_word,
    output logic              rx_ie,
    output logic              tx_ie,
    output logic              done_ie,
    output logic              rx_ready,
    output logic              tx_want,
    output logic              done,
    output logic              eng_req,
    output eng_op_e           eng_op,
    output logic              eng_rnw,
    output logic [7:0]        eng_wbyte,
    input  logic              eng_ack,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rbyte
);

    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    seq_state_e       state_q;
    eng_op_e          op_q;
    logic             dir_q, rxie_q, txie_q, doneie_q, en_q;
    logic             ta_q, done_q, err_q, rxr_q, txw_q, rxd_q;
    logic [LEN_W-1:0] len_q, last_q, len_next;
    logic [7:0]       wbyte_q, rbyte_q;
    logic             idle_acc, begin_req, send_req, recv_req, need_eng;
    logic             stat_wr, len_wr, ctrl_wr, xfer_ack;

    // Access classification in the idle state
    always_comb begin
        idle_acc  = (state_q == ST_IDLE) && acc_valid;
        ctrl_wr   = idle_acc && acc_write && acc_sel == SEL_CTRL;
        stat_wr   = idle_acc && acc_write && acc_sel == SEL_STAT;
        len_wr    = idle_acc && acc_write && acc_sel == SEL_LEN;
        begin_req = ctrl_wr && (acc_wdata[CTRL_GO] || acc_wdata[CTRL_EN]);
        send_req  = idle_acc && acc_write && acc_sel == SEL_DATA && ta_q;
        recv_req  = idle_acc && !acc_write && acc_sel == SEL_DATA && ta_q;
        need_eng  = begin_req || send_req || recv_req;
        acc_ready = (idle_acc && !need_eng) || (state_q == ST_FIN);
        xfer_ack  = (state_q == ST_XFER) && eng_ack;
    end

    // Remaining length after the operation now being acknowledged
    always_comb begin
        case (op_q)
            OP_START: len_next = len_q;
            OP_SEND:  len_next = eng_nack ? len_q : len_q - LEN_ONE;
            default:  len_next = len_q - LEN_ONE;
        endcase
    end

    // Sequencer state and latched operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_START;
            wbyte_q <= '0;
            rbyte_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (begin_req) begin
                        op_q    <= OP_START;
                        state_q <= ST_XFER;
                    end else if (send_req) begin
                        op_q    <= OP_SEND;
                        wbyte_q <= acc_wdata[7:0];
                        state_q <= ST_XFER;
                    end else if (recv_req) begin
                        op_q    <= OP_RECV;
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (eng_ack) begin
                        if (op_q == OP_RECV) rbyte_q <= eng_rbyte;
                        state_q <= (len_next == '0) ? ST_STOP : ST_FIN;
                    end
                end
                ST_STOP: if (eng_ack) state_q <= ST_FIN;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Control register; go is one-shot and never stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {dir_q, rxie_q, txie_q, doneie_q, en_q} <= '0;
        end else if (ctrl_wr) begin
            dir_q    <= acc_wdata[CTRL_DIR];
            rxie_q   <= acc_wdata[CTRL_RXIE];
            txie_q   <= acc_wdata[CTRL_TXIE];
            doneie_q <= acc_wdata[CTRL_DONEIE];
            en_q     <= acc_wdata[CTRL_EN];
        end
    end

    // Status flags: set by engine outcomes, cleared by stop or write-1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {ta_q, done_q, err_q, rxr_q, txw_q, rxd_q} <= '0;
        end else begin
            if (stat_wr) begin
                if (acc_wdata[STB_DONE]) done_q <= 1'b0;
                if (acc_wdata[STB_ERR])  err_q  <= 1'b0;
            end
            if (xfer_ack) begin
                if (op_q == OP_START) begin
                    ta_q <= 1'b1;
                    if (dir_q) begin
                        rxr_q <= 1'b1;
                        rxd_q <= 1'b1;
                    end else begin
                        txw_q <= 1'b1;
                    end
                end
                if ((op_q == OP_START || op_q == OP_SEND) && eng_nack) err_q <= 1'b1;
            end
            if (state_q == ST_STOP && eng_ack) begin
                done_q <= 1'b1;
                ta_q   <= 1'b0;
                rxr_q  <= 1'b0;
                txw_q  <= 1'b0;
                rxd_q  <= 1'b0;
            end
        end
    end

    // Length counter with reload copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            last_q <= '0;
        end else if (len_wr) begin
            len_q  <= acc_wdata[LEN_W-1:0];
            last_q <= acc_wdata[LEN_W-1:0];
        end else if (stat_wr && acc_wdata[STB_DONE] && done_q) begin
            len_q  <= last_q;
        end else if (xfer_ack) begin
            len_q  <= len_next;
        end
    end

    // Readback words and engine request fields
    always_comb begin
        ctrl_word                = '0;
        ctrl_word[CTRL_DIR]      = dir_q;
        ctrl_word[CTRL_RXIE]     = rxie_q;
        ctrl_word[CTRL_TXIE]     = txie_q;
        ctrl_word[CTRL_DONEIE]   = doneie_q;
        ctrl_word[CTRL_EN]       = en_q;
        stat_word                = '0;
        stat_word[STB_BUSY]      = ta_q;
        stat_word[STB_DONE]      = done_q;
        stat_word[STB_TXW]       = txw_q;
        stat_word[STB_RXR]       = rxr_q;
        stat_word[STB_TXD]       = 1'b1;
        stat_word[STB_RXD]       = rxd_q;
        stat_word[STB_TXE]       = 1'b1;
        stat_word[STB_ERR]       = err_q;
        stat_word[STB_CLKT]      = 1'b0;
        len_word                 = 32'(len_q);
        data_word                = (state_q == ST_FIN && op_q == OP_RECV) ? 32'(rbyte_q) : '0;
        rx_ie                    = rxie_q;
        tx_ie                    = txie_q;
        done_ie                  = doneie_q;
        rx_ready                 = rxr_q;
        tx_want                  = txw_q;
        done                     = done_q;
        eng_req                  = (state_q == ST_XFER) || (state_q == ST_STOP);
        eng_op                   = (state_q == ST_STOP) ? OP_STOP : op_q;
        eng_rnw                  = dir_q;
        eng_wbyte                = wbyte_q;
    end

    // R2: opening a transfer puts a start request on the engine next cycle
    p_begin_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        begin_req |=> (eng_req && eng_op == OP_START));

    // R3: a refused address leaves the error flag set
    p_addr_nack_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && op_q == OP_START && eng_nack) |=> err_q);

    // R4: zero length at start goes straight to stop
    p_quick_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && op_q == OP_START && len_q == '0) |=> (eng_req && eng_op == OP_STOP));

    // R5: an acknowledged stop leaves done set and the active flags clear
    p_finish_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && eng_ack) |=> (done_q && !ta_q && !rxr_q && !txw_q && !rxd_q));

    // R6: a refused byte does not consume length
    p_nack_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack && op_q == OP_SEND && eng_nack) |=> ($stable(len_q) && err_q));

    // R10: no bus completion while the engine is busy
    p_ready_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> !acc_ready);

    // R10: request held steady until acknowledged
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_op)));

endmodule

// File: rtl/i2c_host_regs.sv
// Module: top of the I2C master register block; decodes offsets, routes
//         accesses to the sequencer and configuration storage, muxes reads.
// Assumes: 32-bit accesses only; offsets are byte offsets, ADDR_W >= 5.
module i2c_host_regs
    import i2c_host_pkg::*;
#(
    parameter int          ADDR_W  = 6,
    parameter int          LEN_W   = 16,
    parameter int          SLV_W   = 7,
    parameter logic [31:0] DIV_RST = 32'h0000_05DC,
    parameter logic [31:0] DEL_RST = 32'h0030_0030,
    parameter logic [31:0] TMO_RST = 32'h0000_0040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              eng_req,
    output logic [1:0]        eng_op,
    output logic [SLV_W-1:0]  eng_slave,
    output logic              eng_rnw,
    output logic [7:0]        eng_wbyte,
    input  logic              eng_ack,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rbyte,
    output logic [31:0]       cfg_div,
    output logic [31:0]       cfg_delay,
    output logic [31:0]       cfg_timeout
);

    reg_sel_e               sel;
    eng_op_e                op_e;
    logic [31:0]            ctrl_word, stat_word, len_word, data_word;
    logic                   rx_ie, tx_ie, done_ie, rx_ready, tx_want, done;
    logic [SLV_W-1:0]       slave_q;
    logic [N_CFG-1:0][31:0] cfg_q;
    logic                   cfg_wr;

    // Offset decode: aligned words 0..7 are mapped, everything else is not
    always_comb begin
        sel = SEL_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            case (int'(bus_addr[ADDR_W-1:2]))
                0: sel = SEL_CTRL;
                1: sel = SEL_STAT;
                2: sel = SEL_LEN;
                3: sel = SEL_SADDR;
                4: sel = SEL_DATA;
                5: sel = SEL_DIV;
                6: sel = SEL_DELAY;
                7: sel = SEL_TMO;
                default: sel = SEL_NONE;
            endcase
        end
    end

    i2c_host_seq #(.LEN_W(LEN_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (bus_valid),
        .acc_write (bus_write),
        .acc_sel   (sel),
        .acc_wdata (bus_wdata),
        .acc_ready (bus_ready),
        .ctrl_word (ctrl_word),
        .stat_word (stat_word),
        .len_word  (len_word),
        .data_word (data_word),
        .rx_ie     (rx_ie),
        .tx_ie     (tx_ie),
        .done_ie   (done_ie),
        .rx_ready  (rx_ready),
        .tx_want   (tx_want),
        .done      (done),
        .eng_req   (eng_req),
        .eng_op    (op_e),
        .eng_rnw   (eng_rnw),
        .eng_wbyte (eng_wbyte),
        .eng_ack   (eng_ack),
        .eng_nack  (eng_nack),
        .eng_rbyte (eng_rbyte)
    );

    // Configuration writes complete in the cycle they are accepted
    always_comb cfg_wr = bus_valid && bus_write && bus_ready;

    i2c_host_cfg #(
        .SLV_W   (SLV_W),
        .DIV_RST (DIV_RST),
        .DEL_RST (DEL_RST),
        .TMO_RST (TMO_RST)
    ) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .slave_q (slave_q),
        .cfg_q   (cfg_q)
    );

    i2c_host_irq irq_i (
        .rx_ie    (rx_ie),
        .tx_ie    (tx_ie),
        .done_ie  (done_ie),
        .rx_ready (rx_ready),
        .tx_want  (tx_want),
        .done     (done),
        .irq      (irq)
    );

    // Read data mux and output wiring
    always_comb begin
        case (sel)
            SEL_CTRL:  bus_rdata = ctrl_word;
            SEL_STAT:  bus_rdata = stat_word;
            SEL_LEN:   bus_rdata = len_word;
            SEL_SADDR: bus_rdata = 32'(slave_q);
            SEL_DATA:  bus_rdata = data_word;
            SEL_DIV:   bus_rdata = cfg_q[0];
            SEL_DELAY: bus_rdata = cfg_q[1];
            SEL_TMO:   bus_rdata = cfg_q[2];
            default:   bus_rdata = '0;
        endcase
        eng_op      = op_e;
        eng_slave   = slave_q;
        cfg_div     = cfg_q[0];
        cfg_delay   = cfg_q[1];
        cfg_timeout = cfg_q[2];
    end

    // R11: unmapped offsets never return data
    p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && sel == SEL_NONE) |-> (bus_ready && bus_rdata == '0));

endmodule

// File: tb/i2c_host_regs_tb_top.sv
module i2c_host_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int LEN_W  = 4;
    localparam int SLV_W  = 7;
    localparam logic [31:0] LEN_MASK = (32'd1 << LEN_W) - 1;
    localparam logic [31:0] CTRL_MASK = 32'h0000_8701;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_ready;
    logic [31:0]       bus_rdata;
    logic              irq;
    logic              eng_req;
    logic [1:0]        eng_op;
    logic [SLV_W-1:0]  eng_slave;
    logic              eng_rnw;
    logic [7:0]        eng_wbyte;
    logic              eng_ack = 1'b0, eng_nack = 1'b0;
    logic [7:0]        eng_rbyte = '0;
    logic [31:0]       cfg_div, cfg_delay, cfg_timeout;

    i2c_host_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SLV_W(SLV_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .irq(irq),
        .eng_req(eng_req), .eng_op(eng_op), .eng_slave(eng_slave),
        .eng_rnw(eng_rnw), .eng_wbyte(eng_wbyte),
        .eng_ack(eng_ack), .eng_nack(eng_nack), .eng_rbyte(eng_rbyte),
        .cfg_div(cfg_div), .cfg_delay(cfg_delay), .cfg_timeout(cfg_timeout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        report();
    end

    // ---------------- engine model ----------------
    bit        addr_nack_mode = 0;
    bit        byte_nack_mode = 0;
    logic [7:0] rx_plan = '0;
    int        lat_cnt = 0;
    bit        eng_busy = 0;
    int        op_cnt = 0, start_cnt = 0, send_cnt = 0, recv_cnt = 0, stop_cnt = 0;
    logic [SLV_W-1:0] start_slave = '0;
    logic       start_rnw = 0;
    logic [7:0] sent_byte = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            eng_ack = 0;
            eng_busy = 0;
        end else if (eng_ack) begin
            eng_ack = 0;
        end else if (eng_req) begin
            if (!eng_busy) begin
                eng_busy = 1;
                lat_cnt = $urandom_range(0, 2);
            end
            if (lat_cnt == 0) begin
                eng_busy = 0;
                eng_ack = 1;
                eng_nack = (eng_op == 2'd0) ? addr_nack_mode :
                           (eng_op == 2'd1) ? byte_nack_mode : 1'b0;
                eng_rbyte = rx_plan;
                op_cnt++;
                case (eng_op)
                    2'd0: begin start_cnt++; start_slave = eng_slave; start_rnw = eng_rnw; end
                    2'd1: begin send_cnt++; sent_byte = eng_wbyte; end
                    2'd2: recv_cnt++;
                    default: stop_cnt++;
                endcase
            end else begin
                lat_cnt--;
            end
        end
    end

    // ---------------- bus access ----------------
    task automatic bus_xfer(input bit wr, input logic [ADDR_W-1:0] a,
                            input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = wd;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
        end
        if (eng_req) check("R10 ready while engine busy", 32'(bus_ready), 32'd0);
        rd = bus_rdata;
        @(posedge clk);
        #1;
        bus_valid = 0;
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_ctrl = 0, m_len = 0, m_last = 0, m_slv = 0;
    logic [31:0] m_div = 32'h5DC, m_del = 32'h0030_0030, m_tmo = 32'h40;
    bit m_ta = 0, m_done = 0, m_err = 0, m_rxr = 0, m_txw = 0, m_rxd = 0;

    function automatic logic [31:0] m_stat();
        logic [31:0] s = 32'h50;
        s[0] = m_ta; s[1] = m_done; s[2] = m_txw; s[3] = m_rxr; s[5] = m_rxd; s[8] = m_err;
        return s;
    endfunction

    function automatic logic m_irq();
        return (m_ctrl[8] & m_rxr) | (m_ctrl[9] & m_txw) | (m_ctrl[10] & m_done);
    endfunction

    task automatic m_finish();
        m_done = 1; m_ta = 0; m_rxr = 0; m_txw = 0; m_rxd = 0;
    endtask

    task automatic wr_ctrl(input logic [31:0] w, input bit anack);
        logic [31:0] rd;
        int s0 = start_cnt, p0 = stop_cnt;
        bit opens = w[4] | w[15];
        addr_nack_mode = anack;
        bus_xfer(1, 6'h00, w, rd);
        m_ctrl = w & CTRL_MASK;
        if (opens) begin
            check("R2 start issued", 32'(start_cnt), 32'(s0 + 1));
            check("R2 start address", 32'(start_slave), m_slv);
            check("R2 start direction", 32'(start_rnw), 32'(m_ctrl[0]));
            if (anack) m_err = 1;
            m_ta = 1;
            if (m_ctrl[0]) begin m_rxr = 1; m_rxd = 1; end else m_txw = 1;
            if (m_len == 0) begin
                m_finish();
                check("R4 quick stop", 32'(stop_cnt), 32'(p0 + 1));
            end
        end
        check("R9 irq after control", 32'(irq), 32'(m_irq()));
    endtask

    task automatic wr_data(input logic [7:0] b, input bit bnack);
        logic [31:0] rd;
        int o0 = op_cnt, s0 = send_cnt, p0 = stop_cnt;
        byte_nack_mode = bnack;
        bus_xfer(1, 6'h10, 32'hA5A5_0000 | 32'(b), rd);
        if (m_ta) begin
            check("R6 send issued", 32'(send_cnt), 32'(s0 + 1));
            check("R6 send byte", 32'(sent_byte), 32'(b));
            if (bnack) m_err = 1; else m_len = (m_len - 1) & LEN_MASK;
            if (m_len == 0) begin
                m_finish();
                check("R5 stop after last byte", 32'(stop_cnt), 32'(p0 + 1));
            end
        end else begin
            check("R6 idle data write ignored", 32'(op_cnt), 32'(o0));
        end
        check("R9 irq after data write", 32'(irq), 32'(m_irq()));
    endtask

    task automatic rd_data();
        logic [31:0] rd;
        int o0 = op_cnt, p0 = stop_cnt;
        rx_plan = 8'($urandom);
        bus_xfer(0, 6'h10, 32'h0, rd);
        if (m_ta) begin
            check("R7 received byte", rd, 32'(rx_plan));
            m_len = (m_len - 1) & LEN_MASK;
            if (m_len == 0) begin
                m_finish();
                check("R5 stop after last read", 32'(stop_cnt), 32'(p0 + 1));
            end
        end else begin
            check("R7 idle data read zero", rd, 32'h0);
            check("R7 idle data read no op", 32'(op_cnt), 32'(o0));
        end
        check("R9 irq after data read", 32'(irq), 32'(m_irq()));
    endtask

    task automatic wr_stat(input logic [31:0] w);
        logic [31:0] rd;
        bus_xfer(1, 6'h04, w, rd);
        if (w[1] && m_done) m_len = m_last;
        if (w[1]) m_done = 0;
        if (w[8]) m_err = 0;
        check("R9 irq after status write", 32'(irq), 32'(m_irq()));
    endtask

    task automatic wr_len(input logic [31:0] w);
        logic [31:0] rd;
        bus_xfer(1, 6'h08, w, rd);
        m_len = w & LEN_MASK;
        m_last = m_len;
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] w);
        logic [31:0] rd;
        bus_xfer(1, a, w, rd);
        case (a)
            6'h0C: m_slv = w & 32'h7F;
            6'h14: m_div = w;
            6'h18: m_del = w;
            6'h1C: m_tmo = w;
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        logic [31:0] rd;
        bus_xfer(0, 6'h00, 0, rd); check({tag, " control"}, rd, m_ctrl);
        bus_xfer(0, 6'h04, 0, rd); check({tag, " status"}, rd, m_stat());
        bus_xfer(0, 6'h08, 0, rd); check({tag, " length"}, rd, m_len);
        bus_xfer(0, 6'h0C, 0, rd); check({tag, " R11 target address"}, rd, m_slv);
        bus_xfer(0, 6'h14, 0, rd); check({tag, " R11 divider"}, rd, m_div);
        bus_xfer(0, 6'h18, 0, rd); check({tag, " R11 delay"}, rd, m_del);
        bus_xfer(0, 6'h1C, 0, rd); check({tag, " R11 timeout"}, rd, m_tmo);
        bus_xfer(0, 6'h20, 0, rd); check({tag, " R11 unmapped 0x20"}, rd, 32'h0);
        check({tag, " R11 cfg_div port"}, cfg_div, m_div);
        check({tag, " R11 cfg_delay port"}, cfg_delay, m_del);
        check({tag, " R11 cfg_timeout port"}, cfg_timeout, m_tmo);
        check({tag, " R9 irq"}, 32'(irq), 32'(m_irq()));
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] rd;
        void'($urandom(32'h1DC0_2024));
        repeat (4) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        check_all("R1 reset");
        check("R1 status reset word", m_stat(), 32'h50);

        // R11: misaligned and high unmapped offsets ignore writes, read zero
        wr_reg(6'h24, 32'hFFFF_FFFF);
        wr_reg(6'h02, 32'hFFFF_FFFF);
        bus_xfer(0, 6'h02, 0, rd); check("R11 misaligned read zero", rd, 32'h0);
        bus_xfer(0, 6'h3C, 0, rd); check("R11 high unmapped read zero", rd, 32'h0);
        check_all("R11 after unmapped writes");

        // R7 / R6: data port while idle
        rd_data();
        wr_data(8'h3C, 0);
        check_all("R6 idle data port");

        // R4: quick command with zero length, done interrupt enabled
        wr_reg(6'h0C, 32'h55);
        wr_ctrl(32'h0000_0410, 0);
        check("R2 go reads back zero", m_ctrl[4] ? 32'h1 : 32'h0, 32'h0);
        check_all("R4 quick command");
        check("R9 done irq raised", 32'(irq), 32'h1);
        wr_stat(32'h2);
        check_all("R8 done cleared");

        // R3: write transfer with address refusal, then two bytes, one refused
        wr_len(2);
        wr_ctrl(32'h0000_0210, 1);
        check_all("R3 write open with address nack");
        check("R9 tx irq", 32'(irq), 32'h1);
        wr_data(8'h11, 1);
        check_all("R6 refused byte keeps length");
        wr_data(8'h22, 0);
        wr_data(8'h33, 0);
        check_all("R5 write transfer finished");
        wr_stat(32'h102);
        check_all("R8 reload length on done clear");
        check("R8 reloaded length", m_len, 32'h2);

        // R7: read transfer of one byte
        wr_len(1);
        wr_ctrl(32'h0000_0111, 0);
        check_all("R3 read open");
        rd_data();
        check_all("R7 read transfer finished");

        // R6: length zero written mid-transfer wraps on a sent byte
        wr_stat(32'h302);
        wr_len(3);
        wr_ctrl(32'h0000_0010, 0);
        wr_len(0);
        wr_data(8'h44, 0);
        check("R6 wrapped length", m_len, LEN_MASK);
        check_all("R6 wrap");

        // random mix
        for (int i = 0; i < 900; i++) begin
            int k = $urandom_range(0, 10);
            case (k)
                0: wr_len($urandom_range(0, 3));
                1: wr_reg(6'h0C, $urandom);
                2: wr_ctrl(($urandom & 32'hFFFF_FFEF & ~32'h8000) |
                           ($urandom_range(0, 1) ? 32'h10 : 32'h0),
                           $urandom_range(0, 3) == 0);
                3, 4: wr_data(8'($urandom), $urandom_range(0, 4) == 0);
                5, 6: rd_data();
                7: wr_stat($urandom & 32'h0000_0302);
                8: wr_reg(6'(5'h14 + 4 * $urandom_range(0, 2)), $urandom);
                9: wr_reg(6'(6'h20 + 4 * $urandom_range(0, 7)), $urandom);
                default: check_all("random sweep");
            endcase
        end
        check_all("final");
        report();
    end

endmodule